// File: doc/BRIEF.md
# In-Band Command Loader

This block is the front stage of a streaming filter pipeline. After a start pulse it takes job commands off an input word stream, seven words per command. For each command it emits one compact control record on a control output and then fetches the job's data through a simple burst read port. The data is the tap coefficients first and then every input sample, row after row. Each fetched word is pushed in order onto a data output. Both outputs feed FIFOs that downstream stages drain at their own pace, so the loader can run a whole job ahead of them and is held back only by back-pressure.

A job with an unusable size is still announced on the control output, marked with an error status, but it causes no memory reads and no data words. The control and data streams therefore stay matched, and no stage has to stop the others. A terminating command closes the batch. It is forwarded as a record with an end status so that later stages can drain. The loader then pulses done and waits for the next start.

Top module: `cmd_loader`

## Requirements
- R1: While reset is held and after it is released, cmd_ready, rd_req_valid, ctl_valid, dat_valid and done are all low.
- R2: A command is seven consecutive input words, in this order: transaction id, row count, column count, tap count, coefficient base, sample base, output base. cmd_ready stays low until start has been pulsed. All seven words of a command are accepted before the first read request for that job is issued.
- R3: Every command produces exactly one control record, in command order. The record carries the transaction id, the row count, the column count, the tap count, the output base truncated to ADDR_W bits, and a status. The status is 0 for a good job, 1 for a bad size and 2 for the end command.
- R4: A job gets status 1 when its column count is greater than MAX_COLS, or when its row count, column count or tap count is zero. Such a job issues no read request and pushes no data word.
- R5: For a good job, the data output carries the tap-count words read from consecutive addresses starting at the coefficient base. These are followed by row-count times column-count words read from consecutive addresses starting at the sample base.
- R6: Each region is read in bursts. Every burst is BURST_MAX words long except the last, which holds the remainder. rd_req_len gives the number of words in the burst, so a region of no more than BURST_MAX words takes exactly one request.
- R7: A command whose transaction id is all ones is the end command. Its record has status 2 and it causes no reads. done is high for exactly one cycle, the cycle after that record is accepted. cmd_ready then stays low until the next start, and a new start runs a new batch in full.
- R8: While ctl_valid, dat_valid or rd_req_valid is high and its ready input is low, the valid stays high and the associated payload stays unchanged in the next cycle. No word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a batch while idle |
| done | output | 1 | One-cycle pulse after the end record is forwarded |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted |
| cmd_data | input | DATA_W | Command word |
| rd_req_valid | output | 1 | Burst read request valid |
| rd_req_ready | input | 1 | Burst read request accepted |
| rd_req_addr | output | ADDR_W | First word address of the burst |
| rd_req_len | output | LEN_W | Number of words in the burst |
| rd_rsp_valid | input | 1 | Read data word valid |
| rd_rsp_ready | output | 1 | Read data word accepted |
| rd_rsp_data | input | DATA_W | Read data word |
| ctl_valid | output | 1 | Control record valid |
| ctl_ready | input | 1 | Control FIFO can accept |
| ctl_txid | output | DATA_W | Record transaction id |
| ctl_rows | output | DATA_W | Record row count |
| ctl_cols | output | DATA_W | Record column count |
| ctl_taps | output | DATA_W | Record tap count |
| ctl_obase | output | ADDR_W | Record output base address |
| ctl_status | output | 2 | 0 good, 1 bad size, 2 end |
| dat_valid | output | 1 | Data word valid |
| dat_ready | input | 1 | Data FIFO can accept |
| dat_data | output | DATA_W | Coefficient or sample word |

## Verification
The bench builds the loader with BURST_MAX at 16, MAX_COLS at 40, a 24-bit address and a 16-bit word counter. With these values, ordinary jobs of up to three rows and up to twenty taps split into many bursts. Directed jobs with exactly 16 and 17 taps hit the single-burst edge and the remainder burst. Column counts of 40 and 41 sit on either side of the size limit. A second batch after the first end command shows that the loader restarts. Random ready and valid gaps on every handshake exercise the hold rules while jobs follow one another.

// File: rtl/cmdld_pkg.sv
package cmdld_pkg;
  localparam int CMD_WORDS = 7;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_BAD_SIZE = 2'd1,
    ST_END      = 2'd2
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CMD  = 3'd1,
    S_CTRL = 3'd2,
    S_COEF = 3'd3,
    S_SAMP = 3'd4,
    S_DONE = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    B_IDLE  = 2'd0,
    B_REQ   = 2'd1,
    B_BEATS = 2'd2
  } burst_e;
endpackage

// File: rtl/cmdld_collect.sv
module cmdld_collect
  import cmdld_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAX_COLS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rec_take,
  output logic              rec_full,
  output logic [DATA_W-1:0] f_tx,
  output logic [DATA_W-1:0] f_rows,
  output logic [DATA_W-1:0] f_cols,
  output logic [DATA_W-1:0] f_taps,
  output logic [DATA_W-1:0] f_hbase,
  output logic [DATA_W-1:0] f_xbase,
  output logic [DATA_W-1:0] f_ybase,
  output status_e           f_status
);
  localparam int IDX_W = $clog2(CMD_WORDS);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              full_q, full_d;
  logic [DATA_W-1:0] word_q [CMD_WORDS];
  logic              fire, last_word;

  assign cmd_ready = enable && !full_q;
  assign fire      = cmd_valid && cmd_ready;
  assign last_word = (idx_q == IDX_W'(CMD_WORDS - 1));

  always_comb begin
    idx_d  = idx_q;
    full_d = full_q;
    if (fire) begin
      idx_d = last_word ? '0 : idx_q + IDX_W'(1);
      if (last_word) full_d = 1'b1;
    end
    if (rec_take) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CMD_WORDS; i++) word_q[i] <= '0;
    end else begin
      for (int i = 0; i < CMD_WORDS; i++) begin
        if (fire && (idx_q == IDX_W'(i))) word_q[i] <= cmd_data;
      end
    end
  end

  assign rec_full = full_q;
  assign f_tx     = word_q[0];
  assign f_rows   = word_q[1];
  assign f_cols   = word_q[2];
  assign f_taps   = word_q[3];
  assign f_hbase  = word_q[4];
  assign f_xbase  = word_q[5];
  assign f_ybase  = word_q[6];

  logic is_end, bad_size;
  assign is_end   = &f_tx;
  assign bad_size = (f_rows == '0) || (f_cols == '0) || (f_taps == '0) ||
                    (f_cols > DATA_W'(MAX_COLS));

  always_comb begin
    if (is_end)        f_status = ST_END;
    else if (bad_size) f_status = ST_BAD_SIZE;
    else               f_status = ST_OK;
  end

  // R2: the sequencer releases a record only once all seven words are held
  a_r2_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rec_take |-> full_q);

  // R2: a record becomes complete only on the seventh accepted word
  a_r2_full_on_seventh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(last_word && cmd_valid));
endmodule

// File: rtl/cmdld_burst.sv
module cmdld_burst
  import cmdld_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int BURST_MAX = 256,
  localparam int LEN_W    = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_base,
  input  logic [CNT_W-1:0]  go_count,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              beat_want,
  input  logic              beat,
  output logic              fin
);
  burst_e            bst_q, bst_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [LEN_W-1:0]  chunk;

  always_comb begin
    if (rem_q > CNT_W'(BURST_MAX)) chunk = LEN_W'(BURST_MAX);
    else                           chunk = rem_q[LEN_W-1:0];
  end

  always_comb begin
    bst_d  = bst_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    left_d = left_q;
    fin    = 1'b0;
    case (bst_q)
      B_REQ: begin
        if (req_ready) begin
          left_d = chunk;
          rem_d  = rem_q - CNT_W'(chunk);
          addr_d = addr_q + ADDR_W'(chunk);
          bst_d  = B_BEATS;
        end
      end
      B_BEATS: begin
        if (beat) begin
          left_d = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            if (rem_q == '0) begin
              bst_d = B_IDLE;
              fin   = 1'b1;
            end else begin
              bst_d = B_REQ;
            end
          end
        end
      end
      default: ;
    endcase
    if (go) begin
      bst_d  = B_REQ;
      addr_d = go_base;
      rem_d  = go_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst_q  <= B_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      left_q <= '0;
    end else begin
      bst_q  <= bst_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      left_q <= left_d;
    end
  end

  assign req_valid = (bst_q == B_REQ);
  assign req_addr  = addr_q;
  assign req_len   = chunk;
  assign beat_want = (bst_q == B_BEATS);

  // R6: each burst is non-empty and no longer than the limit
  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= LEN_W'(BURST_MAX)));

  // R6: response beats are taken only inside an open burst
  a_r6_beat_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (bst_q == B_BEATS));

  // R8: a stalled request keeps its address and length
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));
endmodule

// File: rtl/cmdld_outreg.sv
module cmdld_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              v_q, v_d;
  logic [DATA_W-1:0] d_q;
  logic              load;

  assign in_ready = !v_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    v_d = v_q;
    if (out_ready) v_d = 1'b0;
    if (load)      v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (load) d_q <= in_data;
  end

  assign out_valid = v_q;
  assign out_data  = d_q;

  // R8: a data word waiting on back-pressure is held unchanged
  a_r8_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/cmd_loader.sv
module cmd_loader
  import cmdld_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_COLS  = 1024,
  parameter int BURST_MAX = 256,
  parameter int CNT_W     = 32,
  localparam int LEN_W    = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [LEN_W-1:0]  rd_req_len,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic [DATA_W-1:0] ctl_txid,
  output logic [DATA_W-1:0] ctl_rows,
  output logic [DATA_W-1:0] ctl_cols,
  output logic [DATA_W-1:0] ctl_taps,
  output logic [ADDR_W-1:0] ctl_obase,
  output logic [1:0]        ctl_status,
  input  logic              dat_ready,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_data
);
  phase_e            phase_q, phase_d;
  logic              rec_full, rec_take;
  logic [DATA_W-1:0] f_tx, f_rows, f_cols, f_taps, f_hbase, f_xbase, f_ybase;
  status_e           f_status;
  logic              go, fin, beat_want, beat, or_in_ready;
  logic [ADDR_W-1:0] go_base;
  logic [CNT_W-1:0]  go_count, n_samples;
  logic              ctl_fire;

  cmdld_collect #(.DATA_W(DATA_W), .MAX_COLS(MAX_COLS)) u_collect (
    .clk(clk), .rst_n(rst_n), .enable(phase_q == S_CMD),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rec_take(rec_take), .rec_full(rec_full),
    .f_tx(f_tx), .f_rows(f_rows), .f_cols(f_cols), .f_taps(f_taps),
    .f_hbase(f_hbase), .f_xbase(f_xbase), .f_ybase(f_ybase), .f_status(f_status)
  );

  cmdld_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_MAX(BURST_MAX)) u_burst (
    .clk(clk), .rst_n(rst_n), .go(go), .go_base(go_base), .go_count(go_count),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .req_addr(rd_req_addr), .req_len(rd_req_len),
    .beat_want(beat_want), .beat(beat), .fin(fin)
  );

  cmdld_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rd_rsp_valid && beat_want), .in_ready(or_in_ready), .in_data(rd_rsp_data),
    .out_valid(dat_valid), .out_ready(dat_ready), .out_data(dat_data)
  );

  assign rd_rsp_ready = beat_want && or_in_ready;
  assign beat         = rd_rsp_valid && rd_rsp_ready;
  assign n_samples    = CNT_W'(f_rows) * CNT_W'(f_cols);

  assign ctl_valid  = (phase_q == S_CTRL);
  assign ctl_fire   = ctl_valid && ctl_ready;
  assign ctl_txid   = f_tx;
  assign ctl_rows   = f_rows;
  assign ctl_cols   = f_cols;
  assign ctl_taps   = f_taps;
  assign ctl_obase  = ADDR_W'(f_ybase);
  assign ctl_status = f_status;
  assign done       = (phase_q == S_DONE);

  always_comb begin
    phase_d  = phase_q;
    rec_take = 1'b0;
    go       = 1'b0;
    go_base  = ADDR_W'(f_hbase);
    go_count = CNT_W'(f_taps);
    case (phase_q)
      S_IDLE: if (start) phase_d = S_CMD;
      S_CMD:  if (rec_full) phase_d = S_CTRL;
      S_CTRL: begin
        if (ctl_ready) begin
          case (f_status)
            ST_END:      phase_d = S_DONE;
            ST_BAD_SIZE: begin
              phase_d  = S_CMD;
              rec_take = 1'b1;
            end
            default: begin
              phase_d = S_COEF;
              go      = 1'b1;
            end
          endcase
        end
      end
      S_COEF: begin
        if (fin) begin
          phase_d  = S_SAMP;
          go       = 1'b1;
          go_base  = ADDR_W'(f_xbase);
          go_count = n_samples;
        end
      end
      S_SAMP: begin
        if (fin) begin
          phase_d  = S_CMD;
          rec_take = 1'b1;
        end
      end
      S_DONE: begin
        phase_d  = S_IDLE;
        rec_take = 1'b1;
      end
      default: phase_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= S_IDLE;
    else        phase_q <= phase_d;
  end

  // R8: a stalled control record keeps all of its fields
  a_r8_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && !ctl_ready |=> ctl_valid && $stable(ctl_txid) && $stable(ctl_status) &&
      $stable(ctl_rows) && $stable(ctl_cols) && $stable(ctl_taps) && $stable(ctl_obase));

  // R7: done follows directly on an accepted end record
  a_r7_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ctl_fire && (ctl_status == ST_END)));

  // R7: no command word is taken while idle
  a_r7_idle_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == S_IDLE) |-> !cmd_ready);

  // R4: a bad-size record is never followed by a read request
  a_r4_bad_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fire && (ctl_status == ST_BAD_SIZE) |=> !rd_req_valid);

  // R2: memory is not requested while a command is still being gathered
  a_r2_no_req_while_collecting: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rd_req_valid);
endmodule

// File: tb/cmd_loader_test.sv
`timescale 1ns/1ps
module cmd_loader_test;
  localparam int DW   = 32;
  localparam int AW   = 24;
  localparam int MAXC = 40;
  localparam int BMAX = 16;
  localparam int CW   = 16;
  localparam int LW   = $clog2(BMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          done;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [DW-1:0] cmd_data;
  logic          rd_req_valid;
  logic          rd_req_ready;
  logic [AW-1:0] rd_req_addr;
  logic [LW-1:0] rd_req_len;
  logic          rd_rsp_valid;
  logic          rd_rsp_ready;
  logic [DW-1:0] rd_rsp_data;
  logic          ctl_valid;
  logic          ctl_ready;
  logic [DW-1:0] ctl_txid, ctl_rows, ctl_cols, ctl_taps;
  logic [AW-1:0] ctl_obase;
  logic [1:0]    ctl_status;
  logic          dat_ready;
  logic          dat_valid;
  logic [DW-1:0] dat_data;

  cmd_loader #(.DATA_W(DW), .ADDR_W(AW), .MAX_COLS(MAXC), .BURST_MAX(BMAX), .CNT_W(CW)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int end_cyc = -10;
  int done_cnt = 0;
  int words_taken = 0;
  int job_idx = 0;
  bit ended = 0;
  bit start_pend = 0;

  logic [DW-1:0] cmdq[$];
  logic [DW-1:0] ec_tx[$], ec_rows[$], ec_cols[$], ec_taps[$];
  logic [AW-1:0] ec_ob[$];
  logic [1:0]    ec_st[$];
  logic [DW-1:0] exp_d[$];
  logic [AW-1:0] exp_ra[$];
  int            exp_rl[$];
  int            exp_rj[$];
  logic [AW-1:0] pa[$];
  int            pl[$];

  bit            hold_c, hold_d, hold_r;
  logic [DW-1:0] sv_tx, sv_d;
  logic [1:0]    sv_st;
  logic [AW-1:0] sv_a;
  logic [LW-1:0] sv_l;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return ({8'h00, a} * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic plan_fetch(input logic [AW-1:0] base, input int count, input int job);
    int rem;
    int n;
    logic [AW-1:0] a;
    rem = count;
    a = base;
    while (rem > 0) begin
      n = (rem > BMAX) ? BMAX : rem;
      exp_ra.push_back(a);
      exp_rl.push_back(n);
      exp_rj.push_back(job);
      for (int k = 0; k < n; k++) exp_d.push_back(mem_word(a + AW'(k)));
      a = a + AW'(n);
      rem = rem - n;
    end
  endtask

  task automatic add_job(input logic [DW-1:0] tx, input int rows, input int cols, input int taps,
                         input logic [AW-1:0] hb, input logic [AW-1:0] xb, input logic [AW-1:0] yb);
    logic [1:0] st;
    cmdq.push_back(tx);
    cmdq.push_back(DW'(rows));
    cmdq.push_back(DW'(cols));
    cmdq.push_back(DW'(taps));
    cmdq.push_back(DW'(hb));
    cmdq.push_back(DW'(xb));
    cmdq.push_back(DW'(yb));
    if (tx == 32'hFFFF_FFFF) st = 2'd2;
    else if (rows == 0 || cols == 0 || taps == 0 || cols > MAXC) st = 2'd1;
    else st = 2'd0;
    ec_tx.push_back(tx);
    ec_rows.push_back(DW'(rows));
    ec_cols.push_back(DW'(cols));
    ec_taps.push_back(DW'(taps));
    ec_ob.push_back(yb);
    ec_st.push_back(st);
    if (st == 2'd0) begin
      plan_fetch(hb, taps, job_idx);
      plan_fetch(xb, rows * cols, job_idx);
    end
    job_idx++;
  endtask

  task automatic add_random(input int n);
    int cols;
    for (int j = 0; j < n; j++) begin
      cols = 1 + int'($urandom % MAXC);
      if ($urandom % 6 == 0) cols = MAXC + 1 + int'($urandom % 8);
      add_job($urandom & 32'h0000_FFFF, 1 + int'($urandom % 3), cols, 1 + int'($urandom % 20),
              AW'($urandom & 32'h003F_FF00), AW'($urandom & 32'h003F_FF00), AW'($urandom));
    end
  endtask

  task automatic wait_done(input int target);
    int n;
    n = 0;
    while (done_cnt < target && n < 60000) begin
      @(negedge clk);
      n++;
    end
    if (done_cnt < target) check(1'b0, "R7 watchdog expired before done", 64'(done_cnt), 64'(target));
    repeat (4) @(negedge clk);
    #2;
  endtask

  task automatic check_drained(input string tag);
    check(ec_tx.size() == 0, {"R3 all control records seen ", tag}, 64'(ec_tx.size()), 0);
    check(exp_d.size() == 0, {"R5 all data words seen ", tag}, 64'(exp_d.size()), 0);
    check(exp_ra.size() == 0, {"R6 all bursts requested ", tag}, 64'(exp_ra.size()), 0);
    check(cmdq.size() == 0, {"R2 all command words taken ", tag}, 64'(cmdq.size()), 0);
    check(!ctl_valid && !dat_valid && !rd_req_valid && !cmd_ready, {"R7 idle after batch ", tag},
          {60'd0, ctl_valid, dat_valid, rd_req_valid, cmd_ready}, 0);
  endtask

  // cycle-level driver and monitor
  initial begin
    bit f_cmd, f_req, f_rsp, f_ctl, f_dat;
    start = 0; cmd_valid = 0; cmd_data = 0; rd_req_ready = 0;
    rd_rsp_valid = 0; rd_rsp_data = 0; ctl_ready = 0; dat_ready = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        start = 0; cmd_valid = 0; rd_req_ready = 0; rd_rsp_valid = 0;
        ctl_ready = 0; dat_ready = 0;
      end else begin
        if (hold_c) check(ctl_valid && ctl_txid == sv_tx && ctl_status == sv_st,
                          "R8 control record held", {30'd0, ctl_status, ctl_txid}, {30'd0, sv_st, sv_tx});
        if (hold_d) check(dat_valid && dat_data == sv_d, "R8 data word held", 64'(dat_data), 64'(sv_d));
        if (hold_r) check(rd_req_valid && rd_req_addr == sv_a && rd_req_len == sv_l,
                          "R8 request held", 64'(rd_req_addr), 64'(sv_a));
        start = start_pend;
        if (start_pend) begin
          start_pend = 0;
          ended = 0;
        end
        cmd_valid    = (cmdq.size() > 0) && ($urandom % 4 != 0);
        cmd_data     = (cmdq.size() > 0) ? cmdq[0] : '0;
        rd_req_ready = ($urandom % 3 != 0);
        rd_rsp_valid = (pa.size() > 0) && ($urandom % 4 != 0);
        rd_rsp_data  = (pa.size() > 0) ? mem_word(pa[0]) : '0;
        ctl_ready    = ($urandom % 3 != 0);
        dat_ready    = ($urandom % 4 != 0);
        #1;
        if (done) begin
          check(cyc == end_cyc + 1, "R7 done one cycle after end record", 64'(cyc), 64'(end_cyc + 1));
          check(!cmd_ready, "R7 no command accepted at done", 64'(cmd_ready), 0);
          done_cnt++;
        end
        if (ended && cmd_ready) check(1'b0, "R7 cmd_ready after end", 1, 0);
        f_cmd = cmd_valid && cmd_ready;
        f_req = rd_req_valid && rd_req_ready;
        f_rsp = rd_rsp_valid && rd_rsp_ready;
        f_ctl = ctl_valid && ctl_ready;
        f_dat = dat_valid && dat_ready;
        if (f_cmd) begin
          void'(cmdq.pop_front());
          words_taken++;
        end
        if (f_req) begin
          if (exp_ra.size() == 0) begin
            check(1'b0, "R4 unexpected read request", 64'(rd_req_addr), 0);
          end else begin
            check(rd_req_addr == exp_ra[0], "R5 burst address", 64'(rd_req_addr), 64'(exp_ra[0]));
            check(rd_req_len == LW'(exp_rl[0]), "R6 burst length", 64'(rd_req_len), 64'(exp_rl[0]));
            check(words_taken >= 7 * (exp_rj[0] + 1), "R2 command complete before fetch",
                  64'(words_taken), 64'(7 * (exp_rj[0] + 1)));
            pa.push_back(rd_req_addr);
            pl.push_back(int'(rd_req_len));
            void'(exp_ra.pop_front());
            void'(exp_rl.pop_front());
            void'(exp_rj.pop_front());
          end
        end
        if (f_rsp) begin
          pa[0] = pa[0] + AW'(1);
          pl[0] = pl[0] - 1;
          if (pl[0] == 0) begin
            void'(pa.pop_front());
            void'(pl.pop_front());
          end
        end
        if (f_ctl) begin
          if (ec_tx.size() == 0) begin
            check(1'b0, "R3 unexpected control record", 64'(ctl_txid), 0);
          end else begin
            check(ctl_txid == ec_tx[0], "R3 record transaction id", 64'(ctl_txid), 64'(ec_tx[0]));
            check(ctl_rows == ec_rows[0] && ctl_cols == ec_cols[0] && ctl_taps == ec_taps[0],
                  "R3 record sizes", {ctl_rows[15:0], ctl_cols[15:0], ctl_taps[15:0]},
                  {ec_rows[0][15:0], ec_cols[0][15:0], ec_taps[0][15:0]});
            check(ctl_obase == ec_ob[0], "R3 record output base", 64'(ctl_obase), 64'(ec_ob[0]));
            check(ctl_status == ec_st[0],
                  (ec_st[0] == 2'd1) ? "R4 bad size status" :
                  (ec_st[0] == 2'd2) ? "R7 end status" : "R3 good status",
                  64'(ctl_status), 64'(ec_st[0]));
            if (ctl_status == 2'd2) begin
              ended = 1;
              end_cyc = cyc;
            end
            void'(ec_tx.pop_front()); void'(ec_rows.pop_front()); void'(ec_cols.pop_front());
            void'(ec_taps.pop_front()); void'(ec_ob.pop_front()); void'(ec_st.pop_front());
          end
        end
        if (f_dat) begin
          if (exp_d.size() == 0) begin
            check(1'b0, "R4 unexpected data word", 64'(dat_data), 0);
          end else begin
            check(dat_data == exp_d[0], "R5 data word order", 64'(dat_data), 64'(exp_d[0]));
            void'(exp_d.pop_front());
          end
        end
        hold_c = ctl_valid && !ctl_ready;
        hold_d = dat_valid && !dat_ready;
        hold_r = rd_req_valid && !rd_req_ready;
        sv_tx = ctl_txid; sv_st = ctl_status; sv_d = dat_data;
        sv_a = rd_req_addr; sv_l = rd_req_len;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    hold_c = 0; hold_d = 0; hold_r = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    check(!cmd_ready && !rd_req_valid && !ctl_valid && !dat_valid && !done, "R1 outputs low in reset",
          {59'd0, cmd_ready, rd_req_valid, ctl_valid, dat_valid, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check(!cmd_ready && !rd_req_valid && !ctl_valid && !dat_valid && !done, "R1 outputs low after reset",
          {59'd0, cmd_ready, rd_req_valid, ctl_valid, dat_valid, done}, 0);

    // batch 1: directed corners then random jobs
    add_job(32'h0000_0101, 2, 5, 3, 24'h001000, 24'h002000, 24'h003000);
    add_job(32'h0000_0102, 1, MAXC, 4, 24'h004000, 24'h005000, 24'h006000);     // R4 limit accepted
    add_job(32'h0000_0103, 1, MAXC + 1, 4, 24'h007000, 24'h008000, 24'h009000); // R4 over limit
    add_job(32'h0000_0104, 0, 8, 4, 24'h00A000, 24'h00B000, 24'h00C000);        // R4 zero rows
    add_job(32'h0000_0105, 2, 8, 0, 24'h00D000, 24'h00E000, 24'h00F000);        // R4 zero taps
    add_job(32'h0000_0106, 3, 0, 2, 24'h010000, 24'h011000, 24'h012000);        // R4 zero cols
    add_job(32'h0000_0107, 1, 1, BMAX, 24'h013000, 24'h014000, 24'h015000);     // R6 one burst
    add_job(32'h0000_0108, 1, BMAX + 1, BMAX + 1, 24'h016000, 24'h017000, 24'h018000); // R6 remainder
    add_random(8);
    add_job(32'hFFFF_FFFF, 3, 3, 3, 24'h0, 24'h0, 24'h0ABCDE);
    repeat (6) @(negedge clk);
    check(words_taken == 0, "R2 no command words before start", 64'(words_taken), 0);
    start_pend = 1;
    wait_done(1);
    check_drained("batch 1");

    // batch 2: restart after end
    add_random(6);
    add_job(32'h0000_0200, 1, 2, 2, 24'h020000, 24'h021000, 24'h022000);
    add_job(32'hFFFF_FFFF, 0, 0, 0, 24'h0, 24'h0, 24'h0);
    start_pend = 1;
    wait_done(2);
    check_drained("batch 2");
    check(done_cnt == 2, "R7 one done per batch", 64'(done_cnt), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule